// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a FIFO's storage and produces its two programmable warning flags: an almost-empty flag that counts from the empty boundary and an almost-full flag that counts from the full boundary. It holds one threshold register for each flag. The FIFO supplies its current occupancy and a strobe for each read or write move. The block compares the occupancy against the two thresholds and updates the flags at the moments the selected timing mode allows.

The thresholds have three sources. A master reset loads a pair of equal values from a small built-in table, and three configuration inputs sampled during that reset pick the entry. After that, software can overwrite the thresholds one bit at a time through a shift port, or one whole value at a time from the write data bus. A read-side readback returns them on the read data bus. Both load paths and the readback fill or visit the almost-empty threshold first and the almost-full threshold second, then wrap. A partial reset restarts these sequences and re-evaluates the flags, but keeps the thresholds and the timing mode.

All three sides share one clock. Each side is marked by its own enable: write side, read side and shift port.

Top module: `pf_flag_unit`

## Requirements
- R1: While `mrst` is high, both thresholds take the table value 2^(i+3)-1 clamped to DEPTH-1, where i = {fsel[1], fsel[0], ld} (0..7). The timing mode takes `pfm_sync` (1 = synchronous, 0 = split). `dout` clears to 0, and both flags are evaluated from `occ` against the table value.
- R2: A cycle with `wr_en` and `ld` high writes `din[OFF_W-1:0]` into the threshold chosen by the load pointer. The pointer starts at almost-empty, alternates with every completed load and wraps after almost-full.
- R3: A cycle with `ser_en` and `ld` high, and no parallel load, shifts `ser_in` into the LSB of the chosen threshold (most significant bit sent first). After OFF_W shifts the load pointer moves on. A parallel load restarts the bit count.
- R4: A cycle with `rd_en` and `ld` high places one threshold, zero-extended, on `dout` in the next cycle. Almost-empty comes first, then almost-full, alternating through a pointer of its own. `dout` holds at all other times.
- R5: Both flags are active low. Almost-empty is due when occ <= empty threshold. Almost-full is due when occ >= DEPTH - full threshold.
- R6: In synchronous mode `ae_n` changes only in cycles with a read move (`rd_en` high, `ld` low), and `af_n` changes only in cycles with a write move (`wr_en` high, `ld` low). Each takes the value R5 gives.
- R7: In split mode `ae_n` falls on a read move when it is due and rises on a write move when it is not due. `af_n` falls on a write move when due and rises on a read move when not due. If neither applies, the flag holds.
- R8: While `prst` is high, the load pointer, bit count and readback pointer return to their start. The thresholds, the timing mode and `dout` are kept, and both flags are evaluated from `occ` as in R5.
- R9: Cycles with `ld` high are load or readback cycles, never read or write moves, so they leave the flags unchanged.
- R10: During and right after `rst_n` low, both thresholds hold 7 (clamped to DEPTH-1), the mode is synchronous, `ae_n` is 0, `af_n` is 1 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all three sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mrst | input | 1 | Master reset: loads table thresholds and latches mode |
| prst | input | 1 | Partial reset: restarts sequences, keeps thresholds |
| pfm_sync | input | 1 | Timing mode sampled at master reset (1 = synchronous) |
| fsel | input | 2 | Default table select, sampled at master reset |
| ld | input | 1 | Turns enables into load/readback cycles; table select bit at master reset |
| wr_en | input | 1 | Write-side enable |
| din | input | DATA_W | Write data bus, low OFF_W bits carry a threshold |
| rd_en | input | 1 | Read-side enable |
| dout | output | DATA_W | Threshold readback |
| ser_en | input | 1 | Shift-port enable |
| ser_in | input | 1 | Shift-port data bit |
| occ | input | CNT_W | FIFO occupancy, 0..DEPTH |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the unit with DEPTH = 64, which gives 6-bit thresholds, a 7-bit occupancy and an 8-bit data bus. At that depth random occupancies often land on both sides of each threshold and on the full boundary itself. The upper table entries (63 and above) saturate at DEPTH-1, so the clamp is exercised. The 6-bit threshold keeps a complete serial word short enough that a partial reset can cut into the middle of one. Both timing modes receive several hundred cycles of random read and write moves, with occupancy jumps that make the split-mode set and clear rules disagree with the synchronous ones.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } pf_sel_e;

  // Default threshold table: 2^(idx+3)-1, saturated at depth-1
  function automatic int unsigned dflt_offset(input logic [2:0] idx, input int unsigned depth);
    int unsigned v;
    v = (32'd1 << (idx + 3)) - 32'd1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

endpackage

// File: rtl/pf_offset_bank.sv
module pf_offset_bank #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int BC_W  = (OFF_W > 1) ? $clog2(OFF_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic [OFF_W-1:0]  dflt,
  input  logic              wr_ld,
  input  logic              ser_ld,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_ld,
  output logic [OFF_W-1:0]  empty_off,
  output logic [OFF_W-1:0]  full_off,
  output logic [DATA_W-1:0] dout
);
  import pf_pkg::*;

  localparam logic [OFF_W-1:0] RST_OFF  = OFF_W'(dflt_offset(3'd0, DEPTH));
  localparam logic [BC_W-1:0]  LAST_BIT = BC_W'(OFF_W - 1);

  logic [OFF_W-1:0]  off_q [2];
  logic [OFF_W-1:0]  off_d [2];
  pf_sel_e           ld_ptr_q, ld_ptr_d;
  pf_sel_e           rb_ptr_q, rb_ptr_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [OFF_W-1:0]  din_lo;

  assign din_lo = din[OFF_W-1:0];

  generate
    if (DATA_W > OFF_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^din[DATA_W-1:OFF_W];
    end
  endgenerate

  always_comb begin
    off_d    = off_q;
    ld_ptr_d = ld_ptr_q;
    rb_ptr_d = rb_ptr_q;
    bc_d     = bc_q;
    dout_d   = dout_q;
    if (mrst) begin
      off_d[SEL_EMPTY] = dflt;
      off_d[SEL_FULL]  = dflt;
      ld_ptr_d = SEL_EMPTY;
      rb_ptr_d = SEL_EMPTY;
      bc_d     = '0;
      dout_d   = '0;
    end else if (prst) begin
      ld_ptr_d = SEL_EMPTY;
      rb_ptr_d = SEL_EMPTY;
      bc_d     = '0;
    end else begin
      if (wr_ld) begin
        off_d[ld_ptr_q] = din_lo;
        ld_ptr_d = pf_sel_e'(~ld_ptr_q);
        bc_d     = '0;
      end else if (ser_ld) begin
        off_d[ld_ptr_q] = {off_q[ld_ptr_q][OFF_W-2:0], ser_in};
        if (bc_q == LAST_BIT) begin
          bc_d     = '0;
          ld_ptr_d = pf_sel_e'(~ld_ptr_q);
        end else begin
          bc_d = bc_q + 1'b1;
        end
      end
      if (rd_ld) begin
        dout_d   = DATA_W'(off_q[rb_ptr_q]);
        rb_ptr_d = pf_sel_e'(~rb_ptr_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q[SEL_EMPTY] <= RST_OFF;
      off_q[SEL_FULL]  <= RST_OFF;
      ld_ptr_q <= SEL_EMPTY;
      rb_ptr_q <= SEL_EMPTY;
      bc_q     <= '0;
      dout_q   <= '0;
    end else begin
      off_q    <= off_d;
      ld_ptr_q <= ld_ptr_d;
      rb_ptr_q <= rb_ptr_d;
      bc_q     <= bc_d;
      dout_q   <= dout_d;
    end
  end

  assign empty_off = off_q[SEL_EMPTY];
  assign full_off  = off_q[SEL_FULL];
  assign dout      = dout_q;

  // R8
  offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !wr_ld && !ser_ld) |=> ($stable(empty_off) && $stable(full_off)));

  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_q <= LAST_BIT);

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst && !rd_ld) |=> $stable(dout));

endmodule

// File: rtl/pf_flag_core.sv
module pf_flag_core #(
  parameter int DEPTH  = 1024,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst,
  input  logic             prst,
  input  logic             pfm_sync,
  input  logic [CNT_W-1:0] occ,
  input  logic [OFF_W-1:0] empty_thr,
  input  logic [OFF_W-1:0] full_thr,
  input  logic             rd_mv,
  input  logic             wr_mv,
  output logic             ae_n,
  output logic             af_n
);

  localparam logic [CNT_W:0] DEPTH_V = (CNT_W + 1)'(DEPTH);

  logic sync_q, sync_d;
  logic ae_n_q, ae_n_d;
  logic af_n_q, af_n_d;
  logic ae_due, af_due;

  always_comb begin
    ae_due = (occ <= CNT_W'(empty_thr));
    af_due = (({1'b0, occ} + (CNT_W + 1)'(full_thr)) >= DEPTH_V);
  end

  always_comb begin
    sync_d = sync_q;
    ae_n_d = ae_n_q;
    af_n_d = af_n_q;
    if (mrst) begin
      sync_d = pfm_sync;
      ae_n_d = !ae_due;
      af_n_d = !af_due;
    end else if (prst) begin
      ae_n_d = !ae_due;
      af_n_d = !af_due;
    end else if (sync_q) begin
      if (rd_mv) ae_n_d = !ae_due;
      if (wr_mv) af_n_d = !af_due;
    end else begin
      if (rd_mv && ae_due)       ae_n_d = 1'b0;
      else if (wr_mv && !ae_due) ae_n_d = 1'b1;
      if (wr_mv && af_due)       af_n_d = 1'b0;
      else if (rd_mv && !af_due) af_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      ae_n_q <= 1'b0;
      af_n_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      ae_n_q <= ae_n_d;
      af_n_q <= af_n_d;
    end
  end

  assign ae_n = ae_n_q;
  assign af_n = af_n_q;

  // R6
  sync_ae_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !rd_mv && !mrst && !prst) |=> $stable(ae_n));

  // R6
  sync_af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !wr_mv && !mrst && !prst) |=> $stable(af_n));

  // R7
  split_ae_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && !rd_mv && !mrst && !prst) |=> !$fell(ae_n));

  // R7
  split_af_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && !wr_mv && !mrst && !prst) |=> !$fell(af_n));

endmodule

// File: rtl/pf_flag_unit.sv
module pf_flag_unit #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              pfm_sync,
  input  logic [1:0]        fsel,
  input  logic              ld,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [CNT_W-1:0]  occ,
  output logic              ae_n,
  output logic              af_n
);
  import pf_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [OFF_W-1:0] dflt;
  logic [OFF_W-1:0] empty_off, full_off;
  logic [OFF_W-1:0] empty_thr, full_thr;
  logic             wr_ld, rd_ld, ser_ld, wr_mv, rd_mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    dflt      = OFF_W'(dflt_offset({fsel, ld}, DEPTH));
    wr_ld     = wr_en & ld;
    rd_ld     = rd_en & ld;
    ser_ld    = ser_en & ld;
    wr_mv     = wr_en & ~ld;
    rd_mv     = rd_en & ~ld;
    empty_thr = mrst ? dflt : empty_off;
    full_thr  = mrst ? dflt : full_off;
  end

  pf_offset_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mrst      (mrst),
    .prst      (prst),
    .dflt      (dflt),
    .wr_ld     (wr_ld),
    .ser_ld    (ser_ld),
    .ser_in    (ser_in),
    .din       (din),
    .rd_ld     (rd_ld),
    .empty_off (empty_off),
    .full_off  (full_off),
    .dout      (dout)
  );

  pf_flag_core #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mrst      (mrst),
    .prst      (prst),
    .pfm_sync  (pfm_sync),
    .occ       (occ),
    .empty_thr (empty_thr),
    .full_thr  (full_thr),
    .rd_mv     (rd_mv),
    .wr_mv     (wr_mv),
    .ae_n      (ae_n),
    .af_n      (af_n)
  );

  // R9
  ld_no_move_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld && !mrst && !prst) |=> ($stable(ae_n) && $stable(af_n)));

endmodule

// File: tb/pf_flag_unit_tb.sv
module pf_flag_unit_tb;
  localparam int DEPTH  = 64;
  localparam int DATA_W = 8;
  localparam int OFF_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              mrst = 1'b0, prst = 1'b0, pfm_sync = 1'b0;
  logic [1:0]        fsel = 2'b00;
  logic              ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic              ser_en = 1'b0, ser_in = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [CNT_W-1:0]  occ = '0;
  logic [DATA_W-1:0] dout;
  logic              ae_n, af_n;

  pf_flag_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .prst(prst), .pfm_sync(pfm_sync),
    .fsel(fsel), .ld(ld), .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
    .ser_en(ser_en), .ser_in(ser_in), .occ(occ), .ae_n(ae_n), .af_n(af_n)
  );

  always #10 clk = ~clk;

  // reference model state
  int    m_off [2];
  int    m_mode, m_lp, m_bc, m_rp, m_dout, m_aen, m_afn;
  int    checks = 0, errors = 0, cyc = 0;
  bit    live = 1'b0;
  string tag = "R10";

  function automatic int dflt(input int idx);
    int v;
    v = (1 << (idx + 3)) - 1;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v;
  endfunction

  initial begin
    m_off[0] = dflt(0); m_off[1] = dflt(0);
    m_mode = 1; m_lp = 0; m_bc = 0; m_rp = 0; m_dout = 0; m_aen = 0; m_afn = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic int o = int'(occ);
      automatic bit wmv = wr_en && !ld;
      automatic bit rmv = rd_en && !ld;
      automatic bit hae = (o <= m_off[0]);
      automatic bit haf = (o + m_off[1] >= DEPTH);
      if (mrst) begin
        automatic int v = dflt({fsel, ld});
        m_off[0] = v; m_off[1] = v; m_mode = pfm_sync;
        m_lp = 0; m_bc = 0; m_rp = 0; m_dout = 0;
        m_aen = (o <= v) ? 0 : 1;
        m_afn = (o + v >= DEPTH) ? 0 : 1;
      end else if (prst) begin
        m_lp = 0; m_bc = 0; m_rp = 0;
        m_aen = hae ? 0 : 1;
        m_afn = haf ? 0 : 1;
      end else begin
        if (m_mode == 1) begin
          if (rmv) m_aen = hae ? 0 : 1;
          if (wmv) m_afn = haf ? 0 : 1;
        end else begin
          if (rmv && hae) m_aen = 0; else if (wmv && !hae) m_aen = 1;
          if (wmv && haf) m_afn = 0; else if (rmv && !haf) m_afn = 1;
        end
        if (rd_en && ld) begin
          m_dout = m_off[m_rp]; m_rp ^= 1;
        end
        if (wr_en && ld) begin
          m_off[m_lp] = int'(din) % DEPTH; m_lp ^= 1; m_bc = 0;
        end else if (ser_en && ld) begin
          m_off[m_lp] = ((m_off[m_lp] << 1) | int'(ser_in)) % DEPTH;
          if (m_bc == OFF_W - 1) begin m_bc = 0; m_lp ^= 1; end
          else m_bc++;
        end
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("dout", int'(dout), m_dout);
      chk("ae_n", int'(ae_n), m_aen);
      chk("af_n", int'(af_n), m_afn);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ld = 0; wr_en = 0; rd_en = 0; ser_en = 0;
  endtask

  task automatic master(input logic [1:0] fs, input logic l, input logic md, input int o);
    step(); idle(); mrst = 1; fsel = fs; ld = l; pfm_sync = md; occ = CNT_W'(o);
    step(); idle();
  endtask

  task automatic readback2();
    step(); idle(); rd_en = 1; ld = 1;
    step(); step(); idle();
    step();
  endtask

  task automatic ser_word(input int v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      step(); idle(); ser_en = 1; ld = 1; ser_in = v[i];
    end
    step(); idle();
  endtask

  task automatic rand_moves(input int n, input bit with_ld);
    for (int i = 0; i < n; i++) begin
      step(); idle();
      occ   = CNT_W'($urandom_range(0, DEPTH));
      wr_en = $urandom_range(0, 1);
      rd_en = $urandom_range(0, 1);
      if (with_ld && ($urandom_range(0, 7) == 0)) begin
        ld = 1; din = DATA_W'($urandom_range(0, 255));
      end
    end
    step(); idle();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    live = 1'b1;
    repeat (4) step();
    // R10: reset state held through release
    rst_n = 1'b1;
    repeat (3) step();

    // R1: table entry {01,0} -> 31, synchronous mode, occ 0
    tag = "R1";
    master(2'b01, 1'b0, 1'b1, 0);
    tag = "R4"; readback2();

    // R2: parallel load, empty threshold then full threshold
    tag = "R2";
    step(); idle(); wr_en = 1; ld = 1; din = 8'd5;
    step(); din = 8'd9;
    step(); idle();
    tag = "R4"; readback2();

    // R3: serial words, MSB first
    tag = "R3";
    ser_word(44, OFF_W);
    ser_word(3, OFF_W);
    tag = "R4"; readback2();

    // R5 R6: synchronous mode flag behaviour
    tag = "R5 R6";
    rand_moves(300, 1'b0);
    // boundary: occ at the thresholds
    step(); idle(); occ = CNT_W'(44); rd_en = 1; wr_en = 1;
    step(); idle(); occ = CNT_W'(45); rd_en = 1;
    step(); idle(); occ = CNT_W'(DEPTH - 3); wr_en = 1;
    step(); idle(); occ = CNT_W'(DEPTH - 4); wr_en = 1;
    step(); idle();

    // R9: ld-qualified cycles are no moves
    tag = "R9";
    step(); idle(); occ = CNT_W'(0); rd_en = 1; ld = 1;
    step(); occ = CNT_W'(DEPTH);
    step(); wr_en = 1; rd_en = 0; din = 8'd20;
    step(); idle();

    // R8: partial reset mid serial word
    tag = "R8";
    for (int i = 0; i < 3; i++) begin
      step(); idle(); ser_en = 1; ld = 1; ser_in = 1'b1;
    end
    step(); idle(); prst = 1; occ = CNT_W'(10);
    step(); idle();
    ser_word(17, OFF_W);
    readback2();
    step(); idle(); prst = 1; occ = CNT_W'(60);
    step(); idle();
    readback2();

    // R1: clamped top entry, split mode
    tag = "R1";
    master(2'b11, 1'b1, 1'b0, 40);
    readback2();

    // R7: split mode set/clear rules
    tag = "R7";
    rand_moves(300, 1'b0);

    // R1: smallest entry, then mixed moves and loads
    tag = "R1";
    master(2'b00, 1'b0, 1'b0, 3);
    readback2();
    tag = "R9";
    rand_moves(200, 1'b1);
    tag = "R4"; readback2();

    live = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule